// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This block gathers single-cycle event pulses from the datapath of a network controller into a sticky cause register and drives one level-sensitive interrupt line. Software sees it through a small single-cycle register bus. It can enable causes by writing ones to a set address and disable them by writing ones to a separate clear address. It services interrupts by reading the cause register. It can also acknowledge individual causes by writing ones back to that register.

A read of the cause register can clear it. Whether it does depends on the mask and on an auto-mask control bit. With auto-mask enabled, the same read also disables a software-chosen group of mask bits. In message-signalled mode, a per-vector "message sent" strobe clears the cause bits that software has marked for auto-clear. The clearing rules exist so that a later event, such as a second link-status change, always lands in a clean register and raises the line again. It is never hidden behind a bit that was read earlier and left stale.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset all registers read zero and irq_o is low.
- R2: An event_i pulse on bit i sets cause bit i at the next clock edge. If any clear of bit i falls in the same cycle, the event wins and bit i stays set.
- R3: A read of the cause register (word address 0) returns bits 30:0 as stored. Bit 31 is the summary bit and reads 1 exactly when some cause bit is set whose mask bit is also set.
- R4: A cause read while the summary bit is 1 clears all cause bits after returning the value.
- R5: A cause read while the mask is all zero clears all cause bits. With a nonzero mask, auto-mask off and the summary bit 0, a read leaves the cause bits unchanged.
- R6: With control bit 0 (auto-mask enable, control at word address 5) set, a cause read clears all cause bits. It also clears the mask bits selected by the auto-mask register (word address 3, read/write).
- R7: Writing to the cause register clears the cause bits written as 1 and leaves bits written as 0 unchanged.
- R8: Writing ones to word address 1 sets mask bits, and writing ones to word address 2 clears them. Reading address 1 returns the mask, and reading address 2 returns zero.
- R9: With control bit 1 (message mode) set, a pulse on msg_sent_i[v] clears each cause bit i where i mod NUM_VEC equals v and bit i of the auto-clear register (word address 4, read/write) is set. With control bit 1 clear, msg_sent_i has no effect.
- R10: irq_o is high exactly when some cause bit is set together with its mask bit.
- R11: After a cause read has cleared an enabled event, a new pulse of the same event sets the bit again and raises irq_o again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 31 | Event pulses, one per cause bit |
| msg_sent_i | input | NUM_VEC | Per-vector interrupt message sent strobe |
| req_valid_i | input | 1 | Register access valid this cycle |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 3 | Word address |
| req_wdata_i | input | 32 | Write data |
| req_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets the read-clear conditions. One read has enabled causes pending, one has a mask of zero, and one has only disabled causes pending under a nonzero mask. A design that treats the last case like the first loses causes that software has not yet looked at. A design that never clears on read leaves a stale bit that hides a second link-status event. The bench pulses events in the same cycle as a write-one-to-clear and as a clearing read, where a wrong priority drops the new event. In message mode it sends strobes on vectors whose cause bits are and are not marked for auto-clear. It also sends strobes with message mode off, to catch clears on the wrong vector or clears that ignore the mode.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int DATA_W  = 32;
  localparam int CAUSE_W = DATA_W - 1;
  localparam int ADDR_W  = 3;
  localparam int SUM_BIT = DATA_W - 1;

  localparam int CTRL_AM_BIT  = 0;
  localparam int CTRL_MSG_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_CAUSE    = 3'd0,
    REG_MASK     = 3'd1,
    REG_MASK_CLR = 3'd2,
    REG_AUTOMASK = 3'd3,
    REG_AUTOCLR  = 3'd4,
    REG_CTRL     = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic cause_rd;
    logic cause_wr;
    logic mask_set;
    logic mask_clr;
    logic am_wr;
    logic ac_wr;
    logic ctrl_wr;
  } strobe_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_cause_pkg::*;
(
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output strobe_t           strobe_o
);
  always_comb begin
    strobe_o = '0;
    if (valid_i) begin
      case (addr_i)
        REG_CAUSE: begin
          strobe_o.cause_rd = !write_i;
          strobe_o.cause_wr = write_i;
        end
        REG_MASK:     strobe_o.mask_set = write_i;
        REG_MASK_CLR: strobe_o.mask_clr = write_i;
        REG_AUTOMASK: strobe_o.am_wr    = write_i;
        REG_AUTOCLR:  strobe_o.ac_wr    = write_i;
        REG_CTRL:     strobe_o.ctrl_wr  = write_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int W = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] event_i,
  input  logic [W-1:0] w1c_i,
  input  logic         clr_all_i,
  input  logic [W-1:0] ac_clr_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q;
  logic [W-1:0] clr_vec;

  assign clr_vec = w1c_i | ac_clr_i | {W{clr_all_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= (cause_q & ~clr_vec) | event_i;
  end

  assign cause_o = cause_q;

  p_event_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> ((cause_q & $past(event_i)) == $past(event_i)));

  p_rd_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all_i && event_i == '0) |=> (cause_q == '0));

  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c_i != '0 && event_i == '0) |=> ((cause_q & $past(w1c_i)) == '0));

  p_autoclr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ac_clr_i != '0 && event_i == '0) |=> ((cause_q & $past(ac_clr_i)) == '0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic         am_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         am_clr_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] automask_o
);
  logic [W-1:0] mask_q, automask_q;
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (set_we_i) mask_d = mask_d | wdata_i;
    if (clr_we_i) mask_d = mask_d & ~wdata_i;
    if (am_clr_i) mask_d = mask_d & ~automask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q     <= '0;
      automask_q <= '0;
    end else begin
      mask_q <= mask_d;
      if (am_we_i) automask_q <= wdata_i;
    end
  end

  assign mask_o     = mask_q;
  assign automask_o = automask_q;

  p_mask_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !am_clr_i) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  p_mask_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((mask_q & $past(wdata_i)) == '0));

  p_automask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    am_clr_i |=> ((mask_q & $past(automask_q)) == '0));
endmodule

// File: rtl/irq_autoclr.sv
module irq_autoclr #(
  parameter int W       = 31,
  parameter int NUM_VEC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ac_we_i,
  input  logic [W-1:0]       wdata_i,
  input  logic               msg_mode_i,
  input  logic [NUM_VEC-1:0] msg_sent_i,
  output logic [W-1:0]       autoclr_o,
  output logic [W-1:0]       clr_o
);
  logic [W-1:0] ac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ac_q <= '0;
    else if (ac_we_i) ac_q <= wdata_i;
  end

  // cause bit i belongs to vector i mod NUM_VEC
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign clr_o[i] = msg_mode_i & ac_q[i] & msg_sent_i[i % NUM_VEC];
  end

  assign autoclr_o = ac_q;
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_cause_pkg::*;
#(
  parameter int NUM_VEC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] event_i,
  input  logic [NUM_VEC-1:0] msg_sent_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic [DATA_W-1:0]  req_rdata_o,
  output logic               irq_o
);
  strobe_t            st;
  logic [CAUSE_W-1:0] cause_q, mask_q, automask_q, autoclr_q, ac_clr, w1c;
  logic [CAUSE_W-1:0] wdata_c;
  logic [1:0]         ctrl_q;
  logic               summary, clr_all, am_clr, am_en, msg_mode;
  logic               unused_wdata;

  assign wdata_c      = req_wdata_i[CAUSE_W-1:0];
  assign unused_wdata = req_wdata_i[SUM_BIT];

  irq_reg_decode u_dec (
    .valid_i  (req_valid_i),
    .write_i  (req_write_i),
    .addr_i   (req_addr_i),
    .strobe_o (st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctrl_q <= '0;
    else if (st.ctrl_wr) ctrl_q <= req_wdata_i[1:0];
  end

  assign am_en    = ctrl_q[CTRL_AM_BIT];
  assign msg_mode = ctrl_q[CTRL_MSG_BIT];
  assign summary  = |(cause_q & mask_q);

  // read-to-clear: pending enabled cause, empty mask, or auto-mask mode
  assign clr_all = st.cause_rd & (summary | (mask_q == '0) | am_en);
  assign am_clr  = st.cause_rd & am_en;
  assign w1c     = st.cause_wr ? wdata_c : '0;

  irq_mask_reg #(.W(CAUSE_W)) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_we_i   (st.mask_set),
    .clr_we_i   (st.mask_clr),
    .am_we_i    (st.am_wr),
    .wdata_i    (wdata_c),
    .am_clr_i   (am_clr),
    .mask_o     (mask_q),
    .automask_o (automask_q)
  );

  irq_autoclr #(.W(CAUSE_W), .NUM_VEC(NUM_VEC)) u_ac (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ac_we_i    (st.ac_wr),
    .wdata_i    (wdata_c),
    .msg_mode_i (msg_mode),
    .msg_sent_i (msg_sent_i),
    .autoclr_o  (autoclr_q),
    .clr_o      (ac_clr)
  );

  irq_cause_reg #(.W(CAUSE_W)) u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .event_i   (event_i),
    .w1c_i     (w1c),
    .clr_all_i (clr_all),
    .ac_clr_i  (ac_clr),
    .cause_o   (cause_q)
  );

  always_comb begin
    req_rdata_o = '0;
    case (req_addr_i)
      REG_CAUSE:    req_rdata_o = {summary, cause_q};
      REG_MASK:     req_rdata_o = {1'b0, mask_q};
      REG_AUTOMASK: req_rdata_o = {1'b0, automask_q};
      REG_AUTOCLR:  req_rdata_o = {1'b0, autoclr_q};
      REG_CTRL:     req_rdata_o = {{(DATA_W-2){1'b0}}, ctrl_q};
      default:      req_rdata_o = '0;
    endcase
  end

  assign irq_o = summary;

  p_irq_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((event_i & mask_q) != '0) && !st.mask_clr && !am_clr) |=> irq_o);

  p_no_irq_empty_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);

  p_msg_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msg_mode && !req_valid_i && event_i == '0) |=> (cause_q == $past(cause_q)));
endmodule

// File: tb/tb_irq_cause_unit.sv
module tb_irq_cause_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [30:0] event_i = '0;
  logic [NV-1:0] msg_sent_i = '0;
  logic        req_valid_i = 0, req_write_i = 0;
  logic [2:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [31:0] req_rdata_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_cause_unit #(.NUM_VEC(NV)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 0; req_addr_i = a;
    #1 d = req_rdata_o;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic pulse(logic [30:0] e);
    @(negedge clk_i); event_i = e;
    @(negedge clk_i); event_i = '0;
  endtask

  task automatic msg(logic [NV-1:0] v);
    @(negedge clk_i); msg_sent_i = v;
    @(negedge clk_i); msg_sent_i = '0;
  endtask

  task automatic cleanup();
    bus_wr(3'd5, 32'h0);
    bus_wr(3'd2, 32'hFFFF_FFFF);
    bus_wr(3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      bus_rd(a[2:0], d);
      check("R1 reg zero", d, 32'h0);
    end
    check("R1 irq low", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_summary_clear();
    logic [31:0] d;
    cleanup();
    bus_wr(3'd1, 32'h8);
    bus_rd(3'd1, d);           check("R8 mask set", d, 32'h8);
    bus_rd(3'd2, d);           check("R8 mask-clr reads zero", d, 32'h0);
    pulse(31'h28);
    check("R10 irq high", {31'b0, irq_o}, 32'h1);
    bus_rd(3'd0, d);           check("R3 summary read", d, 32'h8000_0028);
    check("R4 irq low after read", {31'b0, irq_o}, 32'h0);
    bus_rd(3'd0, d);           check("R4 cleared", d, 32'h0);
  endtask

  task automatic t_no_clear_w1c();
    logic [31:0] d;
    cleanup();
    bus_wr(3'd1, 32'h8);
    pulse(31'h20);
    check("R10 disabled cause no irq", {31'b0, irq_o}, 32'h0);
    bus_rd(3'd0, d);           check("R3 no summary", d, 32'h20);
    bus_rd(3'd0, d);           check("R5 kept with nonzero mask", d, 32'h20);
    pulse(31'h06);
    bus_wr(3'd0, 32'h24);
    bus_rd(3'd0, d);           check("R7 w1c", d, 32'h02);
    bus_wr(3'd2, 32'h8);
    bus_rd(3'd1, d);           check("R8 mask clr", d, 32'h0);
    bus_rd(3'd0, d);           check("R5 read zero mask", d, 32'h02);
    bus_rd(3'd0, d);           check("R5 cleared zero mask", d, 32'h0);
  endtask

  task automatic t_event_wins();
    logic [31:0] d;
    cleanup();
    pulse(31'h10);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 1; req_addr_i = 3'd0; req_wdata_i = 32'h10;
    event_i = 31'h10;
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0; event_i = '0;
    bus_rd(3'd0, d);           check("R2 event beats w1c", d, 32'h10);
    bus_wr(3'd1, 32'h10);
    pulse(31'h10);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 0; req_addr_i = 3'd0; event_i = 31'h40;
    #1 d = req_rdata_o;
    @(negedge clk_i);
    req_valid_i = 0; event_i = '0;
    check("R3 read before clear", d, 32'h8000_0010);
    bus_rd(3'd0, d);           check("R2 event beats read clear", d, 32'h40);
  endtask

  task automatic t_automask();
    logic [31:0] d;
    cleanup();
    bus_wr(3'd5, 32'h1);
    bus_wr(3'd3, 32'hC);
    bus_wr(3'd1, 32'hF);
    pulse(31'h100);
    check("R10 no irq", {31'b0, irq_o}, 32'h0);
    bus_rd(3'd0, d);           check("R6 read value", d, 32'h100);
    bus_rd(3'd0, d);           check("R6 cause cleared", d, 32'h0);
    bus_rd(3'd1, d);           check("R6 mask auto-cleared", d, 32'h3);
    bus_rd(3'd3, d);           check("R6 automask reg", d, 32'hC);
  endtask

  task automatic t_msg_autoclr();
    logic [31:0] d;
    cleanup();
    bus_wr(3'd5, 32'h2);
    bus_wr(3'd4, 32'h11);
    pulse(31'h113);
    msg(4'b0001);
    bus_rd(3'd0, d);           check("R9 vector0 clears marked bits", d, 32'h102);
    pulse(31'h2);
    msg(4'b0010);
    bus_rd(3'd0, d);           check("R9 unmarked bit kept", d, 32'h2);
    bus_wr(3'd5, 32'h0);
    bus_wr(3'd4, 32'h2);
    pulse(31'h2);
    msg(4'b0010);
    bus_rd(3'd0, d);           check("R9 mode off ignores strobe", d, 32'h2);
    bus_rd(3'd4, d);           check("R9 autoclr reg", d, 32'h2);
  endtask

  task automatic t_lsc_rearm();
    logic [31:0] d;
    cleanup();
    bus_wr(3'd1, 32'h4);
    pulse(31'h4);
    check("R11 first irq", {31'b0, irq_o}, 32'h1);
    bus_rd(3'd0, d);           check("R11 first read", d, 32'h8000_0004);
    check("R11 irq dropped", {31'b0, irq_o}, 32'h0);
    pulse(31'h4);
    check("R11 irq again", {31'b0, irq_o}, 32'h1);
    bus_rd(3'd0, d);           check("R11 second read", d, 32'h8000_0004);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_summary_clear();
    t_no_clear_w1c();
    t_event_wins();
    t_automask();
    t_msg_autoclr();
    t_lsc_rearm();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule